// File: doc/BRIEF.md
# Bit and Nibble Rotate Unit

This block is the rotate datapath for an 8-bit accumulator machine. It runs four single-bit rotates. Two wrap the end bit straight around the accumulator. Two pass the end bit through the carry flag. It also runs two digit rotates. A digit rotate joins the accumulator low nibble and a memory byte into one 12-bit ring of three nibbles and turns that ring by one nibble. The new accumulator and the new memory byte are then both written back.

The sequencer presents the operation code, the accumulator, the memory data byte already fetched, and the current carry flag, with a valid strobe. One clock later the unit returns the new accumulator, the new memory byte with a write enable, and the new carry flag with an update enable. Address generation and bus timing belong to the surrounding core. The unit never touches the zero or auxiliary-carry flags, so they have no outputs here. The data width is a parameter with a default of 8, and the nibble is half of it.

Top module: `nib_rot_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `res_valid`, `mem_we` and `cy_we` are 0 and `acc_out`, `mem_out` and `cy_out` are 0.
- R2: Outputs are registered. A request sampled with `op_valid` high at a rising edge shows on the outputs right after that edge with `res_valid` high. Without a request, `res_valid` is 0 after the edge.
- R3: Code 3'd0 (rotate right, no carry) gives `acc_out = {a[0], a[7:1]}`, `cy_out = a[0]` and `cy_we = 1`.
- R4: Code 3'd1 (rotate left, no carry) gives `acc_out = {a[6:0], a[7]}`, `cy_out = a[7]` and `cy_we = 1`.
- R5: Code 3'd2 (rotate right through carry) gives `acc_out = {cy_in, a[7:1]}`, `cy_out = a[0]` and `cy_we = 1`.
- R6: Code 3'd3 (rotate left through carry) gives `acc_out = {a[6:0], cy_in}`, `cy_out = a[7]` and `cy_we = 1`.
- R7: Code 3'd4 (digit rotate right) gives `acc_out = {a[7:4], m[3:0]}`, `mem_out = {a[3:0], m[7:4]}`, `mem_we = 1`, `cy_we = 0` and `cy_out = cy_in`.
- R8: Code 3'd5 (digit rotate left) gives `acc_out = {a[7:4], m[7:4]}`, `mem_out = {m[3:0], a[3:0]}`, `mem_we = 1`, `cy_we = 0` and `cy_out = cy_in`.
- R9: Bit rotates keep `mem_we = 0` and return `mem_out = mem_in` unchanged.
- R10: Codes 3'd6 and 3'd7 have no effect. `acc_out`, `mem_out` and `cy_out` equal their inputs, and both enables are 0.
- R11: With `op_valid` low, the next cycle has `res_valid`, `mem_we` and `cy_we` all at 0.
- R12: Six digit rotates in a row in the same direction, each fed the previous result, give back the starting accumulator and memory byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe for this cycle |
| op_sel | input | 3 | Operation code (see R3 to R10) |
| acc_in | input | DATA_W | Current accumulator |
| mem_in | input | DATA_W | Memory byte already read |
| cy_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Result registered from a request |
| acc_out | output | DATA_W | New accumulator |
| mem_out | output | DATA_W | New memory byte |
| mem_we | output | 1 | Write `mem_out` back to memory |
| cy_out | output | 1 | New carry flag |
| cy_we | output | 1 | Update the carry flag |

## Verification
The assertions assume that `op_valid`, `op_sel` and the data inputs are steady around the rising edge and have known values whenever `rst` is low. They also assume that a result is read only in the cycle that follows its request. The bench changes every input on the falling edge only and always drives defined values. It draws the codes from the full 3-bit range, reserved codes included, and it leaves idle cycles so that the enable and valid relations are seen both asserted and deasserted.

// File: rtl/rot_pkg.sv
package rot_pkg;

    typedef enum logic [2:0] {
        OP_RR    = 3'd0,
        OP_RL    = 3'd1,
        OP_RRC   = 3'd2,
        OP_RLC   = 3'd3,
        OP_DIG_R = 3'd4,
        OP_DIG_L = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } rot_op_e;

    typedef struct packed {
        logic is_bit;
        logic is_dig;
        logic left;
        logic thru_cy;
    } rot_dec_t;

    function automatic rot_dec_t rot_decode(input logic [2:0] code);
        rot_dec_t d;
        d = '0;
        case (rot_op_e'(code))
            OP_RR:    begin d.is_bit = 1'b1; end
            OP_RL:    begin d.is_bit = 1'b1; d.left = 1'b1; end
            OP_RRC:   begin d.is_bit = 1'b1; d.thru_cy = 1'b1; end
            OP_RLC:   begin d.is_bit = 1'b1; d.left = 1'b1; d.thru_cy = 1'b1; end
            OP_DIG_R: begin d.is_dig = 1'b1; end
            OP_DIG_L: begin d.is_dig = 1'b1; d.left = 1'b1; end
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rot_bit_path.sv
module rot_bit_path #(
    parameter int DATA_W = 8,
    parameter bit LEFT   = 1'b0
) (
    input  logic [DATA_W-1:0] a,
    input  logic              cy_in,
    input  logic              thru_cy,
    output logic [DATA_W-1:0] r,
    output logic              cy_new
);
    logic fill;

    generate
        if (LEFT) begin : g_left
            assign fill   = thru_cy ? cy_in : a[DATA_W-1];
            assign r      = {a[DATA_W-2:0], fill};
            assign cy_new = a[DATA_W-1];
        end else begin : g_right
            assign fill   = thru_cy ? cy_in : a[0];
            assign r      = {fill, a[DATA_W-1:1]};
            assign cy_new = a[0];
        end
    endgenerate
endmodule

// File: rtl/rot_digit_path.sv
module rot_digit_path #(
    parameter int DATA_W = 8,
    parameter bit LEFT   = 1'b0
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    output logic [DATA_W-1:0] a_new,
    output logic [DATA_W-1:0] m_new
);
    localparam int NIB = DATA_W / 2;

    logic [NIB-1:0] a_lo, m_lo, m_hi;

    assign a_lo = a[NIB-1:0];
    assign m_lo = m[NIB-1:0];
    assign m_hi = m[DATA_W-1:NIB];

    generate
        if (LEFT) begin : g_left
            assign a_new = {a[DATA_W-1:NIB], m_hi};
            assign m_new = {m_lo, a_lo};
        end else begin : g_right
            assign a_new = {a[DATA_W-1:NIB], m_lo};
            assign m_new = {a_lo, m_hi};
        end
    endgenerate
endmodule

// File: rtl/rot_out_stage.sv
module rot_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_d,
    input  logic [DATA_W-1:0] acc_d,
    input  logic [DATA_W-1:0] mem_d,
    input  logic              mwe_d,
    input  logic              cy_d,
    input  logic              cwe_d,
    output logic              vld_q,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] mem_q,
    output logic              mwe_q,
    output logic              cy_q,
    output logic              cwe_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            acc_q <= '0;
            mem_q <= '0;
            mwe_q <= 1'b0;
            cy_q  <= 1'b0;
            cwe_q <= 1'b0;
        end else begin
            vld_q <= vld_d;
            acc_q <= acc_d;
            mem_q <= mem_d;
            mwe_q <= mwe_d;
            cy_q  <= cy_d;
            cwe_q <= cwe_d;
        end
    end
endmodule

// File: rtl/nib_rot_unit.sv
module nib_rot_unit
    import rot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] mem_in,
    input  logic              cy_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] mem_out,
    output logic              mem_we,
    output logic              cy_out,
    output logic              cy_we
);
    localparam int NDIR = 2;

    rot_dec_t dec;
    assign dec = rot_decode(op_sel);

    logic [DATA_W-1:0] bit_r  [NDIR];
    logic              bit_cy [NDIR];
    logic [DATA_W-1:0] dig_a  [NDIR];
    logic [DATA_W-1:0] dig_m  [NDIR];

    generate
        for (genvar g = 0; g < NDIR; g++) begin : g_dir
            rot_bit_path #(.DATA_W(DATA_W), .LEFT(g == 1)) u_bit (
                .a       (acc_in),
                .cy_in   (cy_in),
                .thru_cy (dec.thru_cy),
                .r       (bit_r[g]),
                .cy_new  (bit_cy[g])
            );
            rot_digit_path #(.DATA_W(DATA_W), .LEFT(g == 1)) u_dig (
                .a     (acc_in),
                .m     (mem_in),
                .a_new (dig_a[g]),
                .m_new (dig_m[g])
            );
        end
    endgenerate

    logic [DATA_W-1:0] acc_d, mem_d;
    logic              cy_d, mwe_d, cwe_d;

    always_comb begin
        acc_d = acc_in;
        mem_d = mem_in;
        cy_d  = cy_in;
        mwe_d = 1'b0;
        cwe_d = 1'b0;
        if (op_valid) begin
            if (dec.is_bit) begin
                acc_d = bit_r[dec.left];
                cy_d  = bit_cy[dec.left];
                cwe_d = 1'b1;
            end else if (dec.is_dig) begin
                acc_d = dig_a[dec.left];
                mem_d = dig_m[dec.left];
                mwe_d = 1'b1;
            end
        end
    end

    rot_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .vld_d (op_valid),
        .acc_d (acc_d),
        .mem_d (mem_d),
        .mwe_d (mwe_d),
        .cy_d  (cy_d),
        .cwe_d (cwe_d),
        .vld_q (res_valid),
        .acc_q (acc_out),
        .mem_q (mem_out),
        .mwe_q (mem_we),
        .cy_q  (cy_out),
        .cwe_q (cy_we)
    );
endmodule

// File: rtl/nib_rot_unit_chk.sv
module nib_rot_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [2:0]        op_sel,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] mem_in,
    input logic              cy_in,
    input logic              res_valid,
    input logic [DATA_W-1:0] acc_out,
    input logic [DATA_W-1:0] mem_out,
    input logic              mem_we,
    input logic              cy_out,
    input logic              cy_we
);
    localparam int NIB = DATA_W / 2;

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R11
    mem_we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> res_valid);

    // R11
    cy_we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        cy_we |-> res_valid);

    // R7 R8
    mem_we_digit_only_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(op_sel) == 3'd4 || $past(op_sel) == 3'd5));

    // R7 R8
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, cy_we}));

    // R7 R8
    acc_high_kept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> acc_out[DATA_W-1:NIB] == $past(acc_in[DATA_W-1:NIB]));

    // R9
    mem_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !mem_we) |-> mem_out == $past(mem_in));

    // R3 R4
    ones_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op_sel) <= 3'd1) |->
            $countones(acc_out) == $countones($past(acc_in)));

    // R5
    rrc_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op_sel) == 3'd2) |->
            (cy_out == $past(acc_in[0]) && acc_out[DATA_W-1] == $past(cy_in)));
endmodule

bind nib_rot_unit nib_rot_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .acc_in    (acc_in),
    .mem_in    (mem_in),
    .cy_in     (cy_in),
    .res_valid (res_valid),
    .acc_out   (acc_out),
    .mem_out   (mem_out),
    .mem_we    (mem_we),
    .cy_out    (cy_out),
    .cy_we     (cy_we)
);

// File: tb/nib_rot_unit_bench.sv
module nib_rot_unit_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [2:0]   op_sel = 3'd0;
    logic [W-1:0] acc_in = '0;
    logic [W-1:0] mem_in = '0;
    logic         cy_in = 1'b0;
    logic         res_valid, mem_we, cy_out, cy_we;
    logic [W-1:0] acc_out, mem_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nib_rot_unit #(.DATA_W(W)) u_nib_rot_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .mem_in(mem_in), .cy_in(cy_in),
        .res_valid(res_valid), .acc_out(acc_out), .mem_out(mem_out),
        .mem_we(mem_we), .cy_out(cy_out), .cy_we(cy_we)
    );

    typedef struct packed {
        logic [7:0] acc;
        logic [7:0] mem;
        logic       cy;
        logic       mwe;
        logic       cwe;
    } exp_t;

    function automatic exp_t model(input logic [2:0] op, input logic [7:0] a,
                                   input logic [7:0] m, input logic c);
        exp_t e;
        e = '{acc: a, mem: m, cy: c, mwe: 1'b0, cwe: 1'b0};
        case (op)
            3'd0: begin e.acc = {a[0], a[7:1]}; e.cy = a[0]; e.cwe = 1'b1; end
            3'd1: begin e.acc = {a[6:0], a[7]}; e.cy = a[7]; e.cwe = 1'b1; end
            3'd2: begin e.acc = {c, a[7:1]};    e.cy = a[0]; e.cwe = 1'b1; end
            3'd3: begin e.acc = {a[6:0], c};    e.cy = a[7]; e.cwe = 1'b1; end
            3'd4: begin e.acc = {a[7:4], m[3:0]}; e.mem = {a[3:0], m[7:4]}; e.mwe = 1'b1; end
            3'd5: begin e.acc = {a[7:4], m[7:4]}; e.mem = {m[3:0], a[3:0]}; e.mwe = 1'b1; end
            default: ;
        endcase
        return e;
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive on falling edge, result visible at the next falling edge
    task automatic run_op(input logic [2:0] op, input logic [7:0] a,
                          input logic [7:0] m, input logic c);
        exp_t e;
        string rq;
        op_valid = 1'b1; op_sel = op; acc_in = a; mem_in = m; cy_in = c;
        e = model(op, a, m, c);
        rq = req_of(op);
        @(negedge clk);
        check("R2", "res_valid", {31'd0, res_valid}, 32'd1);
        check(rq, "acc_out", {24'd0, acc_out}, {24'd0, e.acc});
        check(op <= 3'd3 ? "R9" : rq, "mem_out", {24'd0, mem_out}, {24'd0, e.mem});
        check(op <= 3'd3 ? "R9" : rq, "mem_we", {31'd0, mem_we}, {31'd0, e.mwe});
        check(rq, "cy_out", {31'd0, cy_out}, {31'd0, e.cy});
        check(rq, "cy_we", {31'd0, cy_we}, {31'd0, e.cwe});
    endtask

    task automatic idle_check();
        op_valid = 1'b0;
        op_sel = 3'd4;
        acc_in = 8'hA5; mem_in = 8'h3C; cy_in = 1'b1;
        @(negedge clk);
        check("R11", "res_valid", {31'd0, res_valid}, 32'd0);
        check("R11", "mem_we", {31'd0, mem_we}, 32'd0);
        check("R11", "cy_we", {31'd0, cy_we}, 32'd0);
    endtask

    task automatic chain(input logic [2:0] op, input logic [7:0] a0, input logic [7:0] m0);
        logic [7:0] a, m;
        a = a0; m = m0;
        for (int k = 0; k < 6; k++) begin
            op_valid = 1'b1; op_sel = op; acc_in = a; mem_in = m; cy_in = 1'b0;
            @(negedge clk);
            a = acc_out; m = mem_out;
        end
        check("R12", "chain acc", {24'd0, a}, {24'd0, a0});
        check("R12", "chain mem", {24'd0, m}, {24'd0, m0});
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        op_valid = 1'b1; op_sel = 3'd1; acc_in = 8'hFF; mem_in = 8'hFF; cy_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "res_valid in reset", {31'd0, res_valid}, 32'd0);
        check("R1", "enables in reset", {30'd0, mem_we, cy_we}, 32'd0);
        check("R1", "data in reset", {15'd0, acc_out, mem_out, cy_out}, 32'd0);
        rst = 1'b0;
        op_valid = 1'b0;

        // directed corners
        run_op(3'd0, 8'h01, 8'h5A, 1'b0);
        run_op(3'd1, 8'h80, 8'h5A, 1'b0);
        run_op(3'd2, 8'h00, 8'h11, 1'b1);
        run_op(3'd2, 8'hFF, 8'h11, 1'b0);
        run_op(3'd3, 8'h7F, 8'h22, 1'b1);
        run_op(3'd3, 8'h80, 8'h22, 1'b0);
        run_op(3'd4, 8'hC7, 8'h3E, 1'b1);
        run_op(3'd5, 8'hC7, 8'h3E, 1'b0);
        run_op(3'd6, 8'h96, 8'h69, 1'b1);
        run_op(3'd7, 8'h12, 8'h34, 1'b0);
        idle_check();
        chain(3'd4, 8'hB2, 8'h9D);
        chain(3'd5, 8'h4E, 8'hF1);

        // random mix with idle gaps
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0) idle_check();
            else run_op(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom),
                        1'($urandom_range(0, 1)));
        end
        chain(3'd4, 8'($urandom), 8'($urandom));
        chain(3'd5, 8'($urandom), 8'($urandom));
        idle_check();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule